// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Priority Threshold

This block gathers 32 interrupt inputs and presents one request line to the processor. It is programmed through a simple word-addressed register port. Every source has its own control word with a 4-bit priority and a disable flag. Every source also has a trigger word that makes the input either level-sensitive or edge-latched. A 4-bit threshold masks every source whose priority is equal to or above it. The eligible source with the smallest priority value wins, and a tie goes to the lower index.

The register port is a single-cycle port. A write takes effect at the next rising clock edge. Read data follows the address combinationally while the read strobe is high, and any side effect of the read happens at the edge that ends the cycle. Reading the index register claims the winning source. The claim copies the threshold into a saved register and drops the threshold to zero, which blocks further delivery. When service is done, software writes the saved value back to the threshold register. That write also acknowledges the source in service. Two 16-bit shorthand words give bulk access to the disable flags. Two global gates can stop delivery without changing any per-source state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the threshold reads 0xF and the saved threshold reads 0. Every source control word reads 0x40, meaning disabled with priority 0. Every trigger word reads 1. Gate word 0x005 reads 1 and gate word 0x006 reads 0. `cpu_irq` is low and the index register reads 0x80.
- R2: The control word of source n sits at word address 0x040+n. Bits 3:0 hold the priority and bit 6 is the disable flag (1 = disabled). All other bits read as zero, whatever value was written.
- R3: Shorthand word 0x000 bit i is the disable flag of source i. Shorthand word 0x001 bit i is the disable flag of source 16+i. A write through a shorthand word or a control word is visible through the other view.
- R4: A source can win only if it is enabled, pending and its priority is strictly below the threshold (word 0x003, bits 3:0). A threshold of 0 blocks all sources; a threshold of 0xF blocks only priority 15.
- R5: Among the eligible sources the smallest priority value wins, and a tie goes to the lowest index. Reading word 0x002 returns the winning index, or 0x80 when no source is eligible.
- R6: A read of word 0x002 while a winner exists sets the threshold to 0 at the next edge. The same read copies the previous threshold into the saved register at word 0x004, which is read-only.
- R7: Any write to word 0x003 loads the threshold and acknowledges the source claimed last. If that source is edge-latched, its latched pending flag is cleared.
- R8: `cpu_irq` is high exactly when a winner exists, bit 0 of word 0x005 is 1 and bit 0 of word 0x006 is 0.
- R9: Word 0x007 mirrors the threshold and word 0x008 mirrors the saved threshold. Writes to either mirror, and writes to word 0x004, change nothing.
- R10: The trigger word of source n sits at 0x080+n. Writing 1 selects level mode and writing 5 selects edge mode. A write of any other value leaves the word unchanged, and the word reads back 1 or 5.
- R11: In level mode a source is pending only while its input is high. In edge mode a rising input sets a latched pending flag. That flag stays set after the input falls, is not set again while the input stays high, and is cleared only by the acknowledge described in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (claims on the index register) |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq_src | input | 32 | Raw interrupt inputs, bit n is source n |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A corrupted priority, disable flag or threshold shows at once: `cpu_irq` and the index read are both combinational on that state, so a wrong value appears in the same cycle the bad state exists. A claim or acknowledge that misbehaves shows one edge later. The threshold and saved-threshold reads go wrong in the next cycle, or a latched source keeps requesting, or stops requesting, after the acknowledge. The sweeps cover every single source against every threshold and many random multi-source patterns with shorthand masks. Against each of these the bench compares the predicted winner with the index read.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC      = 32,
  parameter int PRIO_W    = 4,
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int IDLE_CODE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NSRC-1:0] irq_src,
  output logic          cpu_irq
);
  localparam int IW   = $clog2(NSRC);
  localparam int HALF = NSRC / 2;
  localparam int DIS_BIT = 6;
  localparam logic [AW-1:0] A_DIS_LO  = AW'(0);
  localparam logic [AW-1:0] A_DIS_HI  = AW'(1);
  localparam logic [AW-1:0] A_IDX     = AW'(2);
  localparam logic [AW-1:0] A_THR     = AW'(3);
  localparam logic [AW-1:0] A_SAVED   = AW'(4);
  localparam logic [AW-1:0] A_GATE_ON = AW'(5);
  localparam logic [AW-1:0] A_GATE_OFF= AW'(6);
  localparam logic [AW-1:0] A_THR_MIR = AW'(7);
  localparam logic [AW-1:0] A_SAV_MIR = AW'(8);
  localparam logic [AW-IW-1:0] PG_CTRL = (AW-IW)'(2);
  localparam logic [AW-IW-1:0] PG_TRIG = (AW-IW)'(4);

  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [NSRC-1:0]   dis_q, edge_q, lat_q, src_q, elig;
  logic [PRIO_W-1:0] thr_q, saved_q;
  logic              gate_on_q, gate_off_q, act_vld_q;
  logic [IW-1:0]     act_idx_q;

  logic              found;
  logic [PRIO_W-1:0] best;
  logic [IW-1:0]     win;

  wire [IW-1:0] sel      = reg_addr[IW-1:0];
  wire          ctrl_wr  = reg_wr && reg_addr[AW-1:IW] == PG_CTRL;
  wire          trig_wr  = reg_wr && reg_addr[AW-1:IW] == PG_TRIG;
  wire          trig_ok  = reg_wdata == DW'(1) || reg_wdata == DW'(5);
  wire          lo_wr    = reg_wr && reg_addr == A_DIS_LO;
  wire          hi_wr    = reg_wr && reg_addr == A_DIS_HI;
  wire          thr_wr   = reg_wr && reg_addr == A_THR;
  wire          claim    = reg_rd && !reg_wr && reg_addr == A_IDX && found;
  wire          ack      = thr_wr && act_vld_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    wire mine   = sel == IW'(g);
    wire sh_wr  = (g < HALF) ? lo_wr : hi_wr;
    wire ack_me = ack && act_idx_q == IW'(g);
    wire rise   = irq_src[g] && !src_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
        dis_q[g]  <= 1'b1;
        edge_q[g] <= 1'b0;
        lat_q[g]  <= 1'b0;
      end else begin
        if (ctrl_wr && mine) begin
          prio_q[g] <= reg_wdata[PRIO_W-1:0];
          dis_q[g]  <= reg_wdata[DIS_BIT];
        end else if (sh_wr) begin
          dis_q[g]  <= reg_wdata[g % HALF];
        end
        if (trig_wr && mine && trig_ok) edge_q[g] <= reg_wdata == DW'(5);
        lat_q[g] <= edge_q[g] && ((lat_q[g] && !ack_me) || rise);
      end
    end

    assign elig[g] = !dis_q[g] && (prio_q[g] < thr_q) &&
                     (edge_q[g] ? lat_q[g] : irq_src[g]);

    a_r11_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_q[g] && lat_q[g] && !ack_me && !(trig_wr && mine)) |=> lat_q[g]);
  end

  always_comb begin
    found = 1'b0;
    best  = '1;
    win   = '0;
    for (int i = 0; i < NSRC; i++)
      if (elig[i] && (!found || prio_q[i] < best)) begin
        found = 1'b1;
        best  = prio_q[i];
        win   = IW'(i);
      end
  end

  assign cpu_irq = found && gate_on_q && !gate_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q      <= '1;
      saved_q    <= '0;
      gate_on_q  <= 1'b1;
      gate_off_q <= 1'b0;
      act_vld_q  <= 1'b0;
      act_idx_q  <= '0;
      src_q      <= '0;
    end else begin
      src_q <= irq_src;
      if (reg_wr && reg_addr == A_GATE_ON)  gate_on_q  <= reg_wdata[0];
      if (reg_wr && reg_addr == A_GATE_OFF) gate_off_q <= reg_wdata[0];
      if (thr_wr) begin
        thr_q     <= reg_wdata[PRIO_W-1:0];
        act_vld_q <= 1'b0;
      end else if (claim) begin
        saved_q   <= thr_q;
        thr_q     <= '0;
        act_vld_q <= 1'b1;
        act_idx_q <= win;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[AW-1:IW] == PG_CTRL) begin
      reg_rdata[PRIO_W-1:0] = prio_q[sel];
      reg_rdata[DIS_BIT]    = dis_q[sel];
    end else if (reg_addr[AW-1:IW] == PG_TRIG) begin
      reg_rdata = edge_q[sel] ? DW'(5) : DW'(1);
    end else begin
      case (reg_addr)
        A_DIS_LO:   reg_rdata[HALF-1:0] = dis_q[HALF-1:0];
        A_DIS_HI:   reg_rdata[HALF-1:0] = dis_q[NSRC-1:HALF];
        A_IDX:      reg_rdata = found ? DW'(win) : DW'(IDLE_CODE);
        A_THR, A_THR_MIR:   reg_rdata[PRIO_W-1:0] = thr_q;
        A_SAVED, A_SAV_MIR: reg_rdata[PRIO_W-1:0] = saved_q;
        A_GATE_ON:  reg_rdata[0] = gate_on_q;
        A_GATE_OFF: reg_rdata[0] = gate_off_q;
        default:    reg_rdata = '0;
      endcase
    end
  end

  a_r6_claim_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (thr_q == '0 && act_vld_q));
  a_r6_claim_saves: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> saved_q == $past(thr_q));
  a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !act_vld_q);
  a_r4_zero_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |-> !cpu_irq);
  a_r8_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_on_q || gate_off_q) |-> !cpu_irq);
  a_r9_saved_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |=> $stable(saved_q));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int P  = 10;
  localparam int AW = 10;

  logic        clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, irq_src = '0;
  logic        cpu_irq;
  int          n_chk = 0, n_bad = 0;
  logic        done = 0;

  always #(P/2) clk = ~clk;

  prio_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_src(irq_src), .cpu_irq(cpu_irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a[AW-1:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a[AW-1:0];
    #(P/4);
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic rdchk(input string req, input int a, input int exp);
    int v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic int prio_of(input int rnd, input int i);
    return rnd == 0 ? (i * 7 + 3) % 16 : (i * 5 + 11) % 16;
  endfunction

  function automatic int exp_win(input logic [31:0] pat, input logic [31:0] dm,
                                 input int rnd, input int t);
    int w = 128, bp = 16;
    for (int i = 0; i < 32; i++)
      if (pat[i] && !dm[i] && prio_of(rnd, i) < t && prio_of(rnd, i) < bp) begin
        bp = prio_of(rnd, i); w = i;
      end
    return w;
  endfunction

  initial begin
    #(P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, t, w;
    logic [31:0] lfsr, dm;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 cpu_irq", cpu_irq, 0);
    rdchk("R1 thr", 3, 15);
    rdchk("R1 saved", 4, 0);
    rdchk("R1 gate_on", 5, 1);
    rdchk("R1 gate_off", 6, 0);
    rdchk("R1 index", 2, 128);
    for (int i = 0; i < 32; i++) begin
      rdchk("R1 ctrl", 64 + i, 'h40);
      rdchk("R1 trig", 128 + i, 1);
    end
    // R2 control layout, junk bits dropped
    for (int i = 0; i < 32; i++)
      wr(64 + i, 32'hFFFF_FF30 | prio_of(0, i) | ((i % 3 == 0) ? 'h40 : 0));
    for (int i = 0; i < 32; i++)
      rdchk("R2 ctrl", 64 + i, prio_of(0, i) | ((i % 3 == 0) ? 'h40 : 0));
    // R3 shorthand coherence
    dm = '0;
    for (int i = 0; i < 32; i++) dm[i] = (i % 3 == 0);
    rdchk("R3 lo view", 0, dm[15:0]);
    rdchk("R3 hi view", 1, dm[31:16]);
    wr(0, 32'h0000_A5C3);
    wr(1, 32'hFFFF_3C96);
    dm = 32'h3C96_A5C3;
    for (int i = 0; i < 32; i++)
      rdchk("R3 ctrl view", 64 + i, prio_of(0, i) | (dm[i] ? 'h40 : 0));
    // R4/R5/R6 single-source sweep over all thresholds
    wr(0, 0); wr(1, 0);
    for (t = 0; t < 16; t++)
      for (int i = 0; i < 32; i++) begin
        wr(3, t);
        irq_src = 32'h1 << i;
        #1;
        chk("R4 mask cpu_irq", cpu_irq, prio_of(0, i) < t);
        w = prio_of(0, i) < t ? i : 128;
        rdchk("R5 index", 2, w);
        if (w != 128) begin
          rdchk("R6 thr zero", 3, 0);
          rdchk("R6 saved", 4, t);
          rdchk("R9 saved mirror", 8, t);
          chk("R6 blocked", cpu_irq, 0);
        end
      end
    // R5 random multi-source with shorthand masks, two priority sets
    lfsr = 32'hACE1_2468;
    for (int rnd = 0; rnd < 2; rnd++) begin
      for (int i = 0; i < 32; i++) wr(64 + i, prio_of(rnd, i));
      for (int k = 0; k < 150; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        dm = {lfsr[7:0], lfsr[31:24], lfsr[15:8], lfsr[23:16]} & {lfsr[23:0], lfsr[31:24]};
        wr(0, dm[15:0]); wr(1, dm[31:16]);
        t = (k % 4 == 0) ? (k / 4) % 16 : 15;
        wr(3, t);
        irq_src = lfsr;
        #1;
        w = exp_win(lfsr, dm, rnd, t);
        chk("R8 cpu_irq follows winner", cpu_irq, w != 128);
        rdchk("R5 winner", 2, w);
      end
    end
    // R8 global gates
    wr(0, 0); wr(1, 0); wr(3, 15);
    irq_src = 32'h1;
    wr(5, 0); #1; chk("R8 gate_on clear", cpu_irq, 0);
    wr(6, 1); #1; chk("R8 both off", cpu_irq, 0);
    wr(5, 1); #1; chk("R8 gate_off set", cpu_irq, 0);
    wr(6, 0); #1; chk("R8 delivered", cpu_irq, 1);
    // R9 read-only saved and mirrors
    wr(3, 9);
    wr(7, 2); wr(8, 3); wr(4, 5);
    rdchk("R9 thr unchanged", 3, 9);
    rdchk("R9 thr mirror", 7, 9);
    rdchk("R9 saved unchanged", 4, 15);
    // R10 trigger type register
    wr(128 + 3, 5); rdchk("R10 type5", 128 + 3, 5);
    wr(128 + 3, 2); rdchk("R10 bad ignored", 128 + 3, 5);
    wr(128 + 3, 7); rdchk("R10 bad ignored", 128 + 3, 5);
    wr(128 + 3, 1); rdchk("R10 type1", 128 + 3, 1);
    // R11 edge latch versus level
    for (int i = 0; i < 32; i++) wr(64 + i, 'h40);
    wr(64 + 3, 2); wr(64 + 4, 2); wr(128 + 3, 5); wr(3, 15);
    irq_src = '0;
    @(negedge clk); irq_src = 32'h8;
    @(negedge clk); irq_src = 32'h0;
    repeat (4) @(negedge clk);
    #1; chk("R11 latched after fall", cpu_irq, 1);
    rdchk("R11 claim index", 2, 3);
    wr(3, 15);
    #1; chk("R7 ack clears latch", cpu_irq, 0);
    rdchk("R7 idle after ack", 2, 128);
    @(negedge clk); irq_src = 32'h8;
    @(negedge clk); #1; chk("R11 new edge", cpu_irq, 1);
    rdchk("R11 claim again", 2, 3);
    wr(3, 15);
    #1; chk("R11 held high no relatch", cpu_irq, 0);
    irq_src = 32'h10;
    #1; chk("R11 level present", cpu_irq, 1);
    irq_src = 32'h0;
    #1; chk("R11 level gone", cpu_irq, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule